// File: doc/BRIEF.md
# Ping-pong OUT endpoint receive buffer

This block holds received data for one OUT endpoint of a USB device controller. It has two packet slots that are used in alternation. On the bus side, a simple receive interface delivers bytes one per strobe and then closes each packet with an end marker that carries a good/bad verdict. The block tells the bus side whether a new packet can be taken. When it cannot, the bus side answers the host with NAK.

On the application side, the block shows which packet is presented through a ready flag, a byte count and a combinational read port that steps one byte per read strobe. A full flag shows that a second packet is waiting behind the presented one. A presented packet is handed back in one of two ways. For a maximum-size packet, it is released automatically once its last byte has been read. For any other packet, the application gives an explicit clear strobe. Use of the second slot is off after reset and is turned on through a small configuration write.

Top module: `ep_out_pingpong`

## Requirements
- R1: After reset, app_rdy, app_full, app_irq and rx_nak are 0, app_cnt is 0, and single-slot mode is active.
- R2: When an rx_eop cycle carries rx_good=1 for an accepted packet, app_rdy is 1 at the next clock edge, and app_cnt equals the number of rx_valid bytes in that packet. A zero-length packet is included and gives app_cnt 0.
- R3: For a packet of exactly DEPTH bytes, the read strobe that takes byte DEPTH-1 releases the packet, and app_rdy is 0 after that edge.
- R4: For a packet shorter than DEPTH bytes, reading all of its bytes leaves app_rdy at 1. Only app_clr releases it.
- R5: When app_clr releases a packet while app_full is 1, app_full and app_rdy are both 0 for one cycle. After that, app_rdy returns to 1 with the count and data of the waiting packet.
- R6: A cfg_wr cycle loads cfg_single. The value 1 (the reset value) allows one held packet. The value 0 allows two.
- R7: rx_nak is 1 whenever the number of held packets equals the allowed number. A packet whose first byte arrives while rx_nak is 1 is discarded whole.
- R8: In single-slot mode, app_full stays 0.
- R9: A packet that ends with rx_good=0 is discarded. The ready, full and count outputs are unchanged by it.
- R10: Packets are presented in arrival order. app_data shows byte number k of the presented packet after k read strobes.
- R11: app_irq is 1 for exactly one cycle each time app_rdy goes from 0 to 1.
- R12: app_rd and app_clr have no effect while app_rdy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load strobe for cfg_single |
| cfg_single | input | 1 | 1: one slot only; 0: both slots in use |
| rx_valid | input | 1 | Data byte strobe from the bus side |
| rx_data | input | DATA_W | Received byte |
| rx_eop | input | 1 | End-of-packet strobe; never in the same cycle as rx_valid |
| rx_good | input | 1 | Packet verdict, sampled with rx_eop |
| rx_nak | output | 1 | No slot free; the bus side must answer NAK |
| app_rdy | output | 1 | A packet is presented to the application |
| app_full | output | 1 | A second packet is held behind the presented one |
| app_cnt | output | CW | Byte count of the presented packet |
| app_rd | input | 1 | Read strobe; advances to the next byte |
| app_data | output | DATA_W | Current byte of the presented packet |
| app_clr | input | 1 | Explicit release of the presented packet |
| app_irq | output | 1 | One-cycle pulse on each rise of app_rdy |

## Verification
The hardest case to reach is a release while the second slot is occupied. This sequence has a one-cycle dip in app_rdy, after which the waiting packet is brought up, and here the count and data must switch to the other slot. To get there, the stimulus first enables the second slot. It then sends a short packet and a full-size packet back to back, adds a third packet that must be refused, and releases the first packet by clear and the second by reading it out. A cycle-accurate behavioural model built on byte and length queues follows every one of these cycles.

// File: rtl/ep_rxbuf_pkg.sv
package ep_rxbuf_pkg;

   // Why the presented packet leaves the application side
   typedef enum logic [1:0] {
      REL_NONE   = 2'd0,
      REL_MANUAL = 2'd1,
      REL_AUTO   = 2'd2
   } rel_cause_e;

   // Physical slot selector for the ping-pong pair
   typedef logic slot_t;

   localparam int unsigned NUM_SLOTS = 2;

   function automatic logic [1:0] allowed_held(input logic single_mode, input bit dbl_capable);
      if (!dbl_capable || single_mode) return 2'd1;
      return 2'd2;
   endfunction

endpackage

// File: rtl/rxb_slot_mem.sv
module rxb_slot_mem #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       wr_en,
   input  ep_rxbuf_pkg::slot_t        wr_slot,
   input  logic [AW-1:0]              wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  ep_rxbuf_pkg::slot_t        rd_slot,
   input  logic [AW-1:0]              rd_addr,
   output logic [DATA_W-1:0]          rd_data
);
   import ep_rxbuf_pkg::*;

   logic [DATA_W-1:0] slot_q [NUM_SLOTS][DEPTH];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (int'(wr_slot) == s))
            slot_q[s][wr_addr] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_slot][rd_addr];

endmodule

// File: rtl/rxb_wr_ctrl.sv
module rxb_wr_ctrl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_eop,
   input  logic              rx_good,
   input  logic              space_free,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic              commit,
   output logic [CW-1:0]     commit_len
);
   logic          in_pkt_q;
   logic          take_q;
   logic [CW-1:0] wptr_q;
   logic          take_now;
   logic          room;

   // Admission is decided once, at the first event of a packet
   assign take_now   = in_pkt_q ? take_q : space_free;
   assign room       = (wptr_q < CW'(DEPTH));
   assign mem_we     = rx_valid && take_now && room;
   assign mem_addr   = wptr_q[AW-1:0];
   assign commit     = rx_eop && rx_good && take_now;
   assign commit_len = wptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt_q <= 1'b0;
         take_q   <= 1'b0;
         wptr_q   <= '0;
      end else if (rx_eop) begin
         in_pkt_q <= 1'b0;
         take_q   <= 1'b0;
         wptr_q   <= '0;
      end else if (rx_valid) begin
         if (!in_pkt_q) begin
            in_pkt_q <= 1'b1;
            take_q   <= space_free;
         end
         if (mem_we)
            wptr_q <= wptr_q + CW'(1);
      end
   end

endmodule

// File: rtl/rxb_flag_ctrl.sv
module rxb_flag_ctrl #(
   parameter int unsigned DEPTH       = 64,
   parameter bit          DBL_CAPABLE = 1'b1,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 single_mode,
   input  logic                 commit,
   input  logic [CW-1:0]        commit_len,
   input  logic                 rd_req,
   input  logic                 clr_req,
   output logic                 space_free,
   output ep_rxbuf_pkg::slot_t  wr_slot,
   output ep_rxbuf_pkg::slot_t  rd_slot,
   output logic [AW-1:0]        rd_addr,
   output logic                 rdy,
   output logic                 full,
   output logic [CW-1:0]        cnt,
   output logic                 irq
);
   import ep_rxbuf_pkg::*;

   logic [1:0]    held_q, held_nxt, cap;
   logic [CW-1:0] len_q [NUM_SLOTS];
   logic [CW-1:0] rd_ptr_q;
   logic [CW-1:0] head_len;
   slot_t         wr_slot_q, rd_slot_q;
   logic          rdy_q, irq_q, rdy_nxt;
   logic          rd_adv;
   rel_cause_e    rel;

   // Variant: a build without the second slot ignores the mode input
   if (DBL_CAPABLE) begin : g_dual
      assign cap = allowed_held(single_mode, 1'b1);
   end else begin : g_single
      assign cap = allowed_held(1'b1, 1'b0);
   end

   assign head_len   = len_q[rd_slot_q];
   assign space_free = (held_q < cap);

   always_comb begin
      rel = REL_NONE;
      if (rdy_q) begin
         if (rd_req && (head_len == CW'(DEPTH)) && (rd_ptr_q == CW'(DEPTH - 1)))
            rel = REL_AUTO;
         else if (clr_req)
            rel = REL_MANUAL;
      end
   end

   assign rd_adv   = rdy_q && rd_req && (rd_ptr_q < head_len);
   assign held_nxt = held_q + {1'b0, commit} - {1'b0, (rel != REL_NONE)};
   // A release always drops ready for one edge; a waiting packet comes up after
   assign rdy_nxt  = (rel == REL_NONE) && (held_nxt != 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= 2'd0;
         wr_slot_q <= 1'b0;
         rd_slot_q <= 1'b0;
         rd_ptr_q  <= '0;
         rdy_q     <= 1'b0;
         irq_q     <= 1'b0;
         for (int i = 0; i < NUM_SLOTS; i++) len_q[i] <= '0;
      end else begin
         held_q <= held_nxt;
         rdy_q  <= rdy_nxt;
         irq_q  <= rdy_nxt && !rdy_q;
         if (commit) begin
            len_q[wr_slot_q] <= commit_len;
            wr_slot_q        <= ~wr_slot_q;
         end
         if (rel != REL_NONE) begin
            rd_slot_q <= ~rd_slot_q;
            rd_ptr_q  <= '0;
         end else if (rd_adv) begin
            rd_ptr_q  <= rd_ptr_q + CW'(1);
         end
      end
   end

   assign wr_slot = wr_slot_q;
   assign rd_slot = rd_slot_q;
   assign rd_addr = rd_ptr_q[AW-1:0];
   assign rdy     = rdy_q;
   assign full    = (held_q == 2'd2);
   assign cnt     = (held_q != 2'd0) ? head_len : '0;
   assign irq     = irq_q;

endmodule

// File: rtl/ep_out_pingpong.sv
module ep_out_pingpong #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 64,
   parameter bit          DBL_CAPABLE = 1'b1,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_single,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_eop,
   input  logic              rx_good,
   output logic              rx_nak,
   output logic              app_rdy,
   output logic              app_full,
   output logic [CW-1:0]     app_cnt,
   input  logic              app_rd,
   output logic [DATA_W-1:0] app_data,
   input  logic              app_clr,
   output logic              app_irq
);
   import ep_rxbuf_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("ep_out_pingpong: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ep_out_pingpong: DEPTH must be a power of two, at least 2");
   end

   logic          single_q;
   logic          space_free;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic          commit;
   logic [CW-1:0] commit_len;
   slot_t         wr_slot, rd_slot;
   logic [AW-1:0] rd_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      single_q <= 1'b1;
      else if (cfg_wr) single_q <= cfg_single;
   end

   rxb_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_eop     (rx_eop),
      .rx_good    (rx_good),
      .space_free (space_free),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .commit     (commit),
      .commit_len (commit_len)
   );

   rxb_flag_ctrl #(.DEPTH(DEPTH), .DBL_CAPABLE(DBL_CAPABLE)) u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .single_mode (single_q),
      .commit      (commit),
      .commit_len  (commit_len),
      .rd_req      (app_rd),
      .clr_req     (app_clr),
      .space_free  (space_free),
      .wr_slot     (wr_slot),
      .rd_slot     (rd_slot),
      .rd_addr     (rd_addr),
      .rdy         (app_rdy),
      .full        (app_full),
      .cnt         (app_cnt),
      .irq         (app_irq)
   );

   rxb_slot_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .wr_en   (mem_we),
      .wr_slot (wr_slot),
      .wr_addr (mem_addr),
      .wr_data (rx_data),
      .rd_slot (rd_slot),
      .rd_addr (rd_addr),
      .rd_data (app_data)
   );

   assign rx_nak = !space_free;

endmodule

// File: rtl/ep_out_pingpong_chk.sv
module ep_out_pingpong_chk #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          single_q,
   input logic          rx_valid,
   input logic          rx_eop,
   input logic          rx_nak,
   input logic          app_rdy,
   input logic          app_full,
   input logic          app_clr,
   input logic [CW-1:0] app_cnt,
   input logic          app_irq
);
   // R7
   full_means_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_full |-> rx_nak);

   // R8
   single_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (single_q && !app_full) |=> !app_full);

   // R5
   full_release_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (app_full && app_rdy && app_clr) |=> (!app_rdy && !app_full) ##1 app_rdy);

   // R11
   irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(app_rdy) |-> app_irq);

   // R11
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_irq |=> !app_irq);

   // R2
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_rdy |-> (app_cnt <= CW'(DEPTH)));

   // R7
   strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_eop));

endmodule

bind ep_out_pingpong ep_out_pingpong_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .single_q (single_q),
   .rx_valid (rx_valid),
   .rx_eop   (rx_eop),
   .rx_nak   (rx_nak),
   .app_rdy  (app_rdy),
   .app_full (app_full),
   .app_clr  (app_clr),
   .app_cnt  (app_cnt),
   .app_irq  (app_irq)
);

// File: tb/tb_ep_out_pingpong.sv
`timescale 1ns/1ps
module tb_ep_out_pingpong;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 64;
   localparam int CW     = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0, cfg_single = 0;
   logic rx_valid = 0, rx_eop = 0, rx_good = 0;
   logic [DATA_W-1:0] rx_data = '0;
   logic rx_nak, app_rdy, app_full, app_irq;
   logic [CW-1:0] app_cnt;
   logic app_rd = 0, app_clr = 0;
   logic [DATA_W-1:0] app_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ep_out_pingpong #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (.*);

   // Behavioural model: held bytes back to back, lengths in a queue
   byte unsigned m_bytes[$];
   int           m_lens[$];
   byte unsigned m_wbuf[$];
   int  m_rdidx = 0;
   bit  m_rdy = 0, m_irq = 0, m_single = 1, m_in = 0, m_take = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bytes.delete(); m_lens.delete(); m_wbuf.delete();
         m_rdidx = 0; m_rdy = 0; m_irq = 0; m_single = 1; m_in = 0; m_take = 0;
      end else begin
         int  cap;
         bit  space, rel, take_now;
         bit  new_rdy;
         cap   = m_single ? 1 : 2;
         space = m_lens.size() < cap;
         rel   = 0;
         if (m_rdy && app_rd && m_lens[0] == DEPTH && m_rdidx == DEPTH - 1) rel = 1;
         else if (m_rdy && app_clr) rel = 1;
         take_now = m_in ? m_take : space;
         if (rel) begin
            for (int i = 0; i < m_lens[0]; i++) void'(m_bytes.pop_front());
            void'(m_lens.pop_front());
            m_rdidx = 0;
         end else if (m_rdy && app_rd && m_rdidx < m_lens[0]) begin
            m_rdidx++;
         end
         if (rx_eop) begin
            if (rx_good && take_now) begin
               m_lens.push_back(m_wbuf.size());
               foreach (m_wbuf[i]) m_bytes.push_back(m_wbuf[i]);
            end
            m_wbuf.delete(); m_in = 0; m_take = 0;
         end else if (rx_valid) begin
            if (!m_in) begin m_in = 1; m_take = space; end
            if (m_take && m_wbuf.size() < DEPTH) m_wbuf.push_back(rx_data);
         end
         if (cfg_wr) m_single = cfg_single;
         new_rdy = !rel && m_lens.size() != 0;
         m_irq = new_rdy && !m_rdy;
         m_rdy = new_rdy;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Every-cycle comparison, 1 ns after the active edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         int cap;
         cap = m_single ? 1 : 2;
         chk("R2 app_rdy", app_rdy, m_rdy);
         chk("R5 app_full", app_full, m_lens.size() == 2);
         chk("R10 app_cnt", app_cnt, m_lens.size() != 0 ? m_lens[0] : 0);
         chk("R7 rx_nak", rx_nak, !(m_lens.size() < cap));
         chk("R11 app_irq", app_irq, m_irq);
         if (m_rdy && m_rdidx < m_lens[0])
            chk("R10 app_data", app_data, m_bytes[m_rdidx]);
      end
   end

   task automatic send_pkt(input int n, input bit good, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rx_valid = 1; rx_data = DATA_W'(seed + i);
      end
      @(negedge clk); rx_valid = 0; rx_eop = 1; rx_good = good;
      @(negedge clk); rx_eop = 0; rx_good = 0;
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); app_rd = 1;
      end
      @(negedge clk); app_rd = 0;
   endtask

   task automatic clear_rdy();
      @(negedge clk); app_clr = 1;
      @(negedge clk); app_clr = 0;
   endtask

   task automatic set_mode(input bit single);
      @(negedge clk); cfg_wr = 1; cfg_single = single;
      @(negedge clk); cfg_wr = 0;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdy", app_rdy, 0); chk("R1 full", app_full, 0);
      chk("R1 nak", rx_nak, 0);  chk("R1 cnt", app_cnt, 0);
      chk("R1 irq", app_irq, 0);

      // Single-slot mode: second packet refused
      send_pkt(5, 1, 10);
      chk("R2 rdy after good packet", app_rdy, 1);
      chk("R2 count", app_cnt, 5);
      chk("R10 first byte", app_data, 10);
      chk("R7 nak when slot taken", rx_nak, 1);
      send_pkt(4, 1, 50);
      chk("R8 no full in single mode", app_full, 0);
      chk("R7 refused packet leaves count", app_cnt, 5);
      read_n(2);
      chk("R10 byte order", app_data, 12);
      read_n(3);
      chk("R4 short packet still ready", app_rdy, 1);
      clear_rdy();
      chk("R4 clear releases", app_rdy, 0);
      read_n(2); clear_rdy();
      chk("R12 strobes ignored when idle", app_rdy, 0);
      chk("R12 nak after ignored strobes", rx_nak, 0);

      // Full-size packet, automatic release
      send_pkt(DEPTH, 1, 0);
      chk("R2 full-size count", app_cnt, DEPTH);
      read_n(DEPTH);
      chk("R3 auto release", app_rdy, 0);

      // Bad packet
      send_pkt(7, 0, 77);
      chk("R9 bad packet ignored rdy", app_rdy, 0);
      chk("R9 bad packet ignored cnt", app_cnt, 0);

      // Two slots
      set_mode(0);
      chk("R6 nak clear with second slot", rx_nak, 0);
      send_pkt(3, 1, 100);
      chk("R6 second slot free", rx_nak, 0);
      send_pkt(DEPTH, 1, 200);
      chk("R5 full with two held", app_full, 1);
      chk("R10 head is first arrival", app_cnt, 3);
      send_pkt(5, 1, 400);
      read_n(3);
      clear_rdy();
      chk("R5 full drops", app_full, 0);
      chk("R5 ready dips", app_rdy, 0);
      @(negedge clk);
      chk("R5 ready returns", app_rdy, 1);
      chk("R11 irq on re-raise", app_irq, 1);
      chk("R10 second packet count", app_cnt, DEPTH);
      chk("R10 second packet data", app_data, 200);
      @(negedge clk);
      chk("R11 irq one cycle", app_irq, 0);
      send_pkt(2, 1, 300);
      read_n(DEPTH);
      @(negedge clk);
      chk("R10 third packet count", app_cnt, 2);
      clear_rdy();

      // Zero-length packet
      send_pkt(0, 1, 0);
      chk("R2 zero-length ready", app_rdy, 1);
      chk("R2 zero-length count", app_cnt, 0);
      clear_rdy();
      set_mode(1);
      send_pkt(1, 1, 9); send_pkt(1, 1, 8);
      chk("R8 full stays low", app_full, 0);
      clear_rdy();
      repeat (4) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule